// File: doc/BRIEF.md
# Multi-mode 16-bit timer counter

This block is a 16-bit timer counter. It moves only on a one-cycle tick strobe that an external prescaler produces. A two-bit mode field selects how it counts. Stopped holds the count. Free-running counts through the full 16-bit range. Modulo counts up to a programmable terminal value and reloads zero. Up/down rises to the terminal value and falls back to zero, which gives a symmetric period. Each overflow event sets a sticky overflow flag. If the overflow mask bit is set, the event also sets a sticky pending flag. An interrupt request is raised while the pending flag, the mask and a separate timer interrupt enable are all set.

Software programs the block through a small byte-wide register port. Writes are synchronous, and reads are combinational from the address. The terminal value is loaded as two bytes without tearing. The current count and the count direction are output pins, so an external comparator can build centre-aligned PWM from them.

Top module: `timer16_multimode`

## Requirements
- R1: Outside a counter-register write, the count changes only in a cycle where `tick` is 1. Each change is a single step of one, or a reload to 0x0000.
- R2: The control register is at address 0. Bits [1:0] select the mode: 00 stopped, 01 free-running, 10 modulo, 11 up/down. Bit 2 is the overflow mask and bit 3 is the timer interrupt enable. In mode 00 a tick leaves the count unchanged.
- R3: In free-running mode each tick adds one. The step from 0xFFFF wraps to 0x0000 and sets the overflow flag.
- R4: In modulo mode a tick adds one while the count is below the terminal value. A tick at or above the terminal value loads 0x0000 and sets the overflow flag.
- R5: In up/down mode the count rises to the terminal value, then falls one per tick to 0x0000, then rises again. The overflow flag is set on the tick that reaches 0x0000. `count_down` is 1 while falling and 0 otherwise.
- R6: With a terminal value of 0x0000 in modulo or up/down mode, every tick leaves the count at 0x0000 and sets the overflow flag.
- R7: A write to address 2 buffers the low terminal byte. A write to address 3 loads the high byte and the buffered low byte together. Reads of addresses 2 and 3 return the low and high bytes of the terminal value in use. The terminal value resets to 0xFFFF.
- R8: The overflow flag is bit 0 of the status register at address 1. It is sticky. Writing 0 to that bit clears it, and writing 1 has no effect. A hardware set in the same cycle wins over the clear.
- R9: The pending flag is status bit 1. An overflow sets it only when the mask (control bit 2) is 1. It is sticky and is cleared by writing 0 to its bit, and a hardware set wins over the clear.
- R10: `irq` is 1 exactly when the pending flag, the mask and the timer interrupt enable are all 1.
- R11: Any write to address 4 or 5 sets the count to 0x0000 and the direction to up. This write wins over a tick in the same cycle, and that tick does not flag an overflow.
- R12: Reads return the low count byte at address 4 and the high count byte at address 5. Addresses 6 and 7 read 0. Unused control and status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaled count strobe, one cycle per step |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| count | output | 16 | Current count |
| count_down | output | 1 | 1 while counting down in up/down mode |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The free-running wrap is the hardest case to reach from the ports. It needs 65,536 consecutive ticks after a count reset, so a directed run ticks on every cycle through the whole range and checks the wrap and the flag. The collision between a hardware flag set and a software clear is also hard to hit by chance. Directed cycles place the status write on the exact tick that reloads, while random phases with small terminal values generate many turnarounds and reloads.

// File: rtl/timer16_multimode.sv
module timer16_multimode (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic [15:0] count,
  output logic        count_down,
  output logic        ovf_flag,
  output logic        irq
);
  localparam logic [1:0] M_STOP = 2'b00;
  localparam logic [1:0] M_FREE = 2'b01;
  localparam logic [1:0] M_MOD  = 2'b10;
  localparam logic [1:0] M_UPDN = 2'b11;

  logic [1:0]  mode_q;
  logic        mask_q, ien_q;
  logic [15:0] term_q;
  logic [7:0]  lo_buf;
  logic [15:0] cnt_q, cnt_n;
  logic        down_q, down_n;
  logic        ovf_q, pend_q;
  logic        hit;

  wire wr_ctl = reg_wr && (reg_addr == 3'd0);
  wire wr_sts = reg_wr && (reg_addr == 3'd1);
  wire wr_tlo = reg_wr && (reg_addr == 3'd2);
  wire wr_thi = reg_wr && (reg_addr == 3'd3);
  wire wr_cnt = reg_wr && (reg_addr == 3'd4 || reg_addr == 3'd5);

  always_comb begin
    cnt_n  = cnt_q;
    down_n = down_q;
    hit    = 1'b0;
    if (tick) begin
      case (mode_q)
        M_FREE: begin
          cnt_n  = cnt_q + 16'd1;
          down_n = 1'b0;
          hit    = (cnt_q == 16'hFFFF);
        end
        M_MOD: begin
          down_n = 1'b0;
          if (cnt_q >= term_q) begin
            cnt_n = 16'h0000;
            hit   = 1'b1;
          end else begin
            cnt_n = cnt_q + 16'd1;
          end
        end
        M_UPDN: begin
          if (term_q == 16'h0000) begin
            cnt_n  = 16'h0000;
            down_n = 1'b0;
            hit    = 1'b1;
          end else if (!down_q && cnt_q < term_q) begin
            cnt_n = cnt_q + 16'd1;
          end else if (cnt_q <= 16'd1) begin
            cnt_n  = 16'h0000;
            down_n = 1'b0;
            hit    = 1'b1;
          end else begin
            cnt_n  = cnt_q - 16'd1;
            down_n = 1'b1;
          end
        end
        default: ;
      endcase
    end
    if (wr_cnt) begin
      cnt_n  = 16'h0000;
      down_n = 1'b0;
      hit    = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_STOP;
      mask_q <= 1'b0;
      ien_q  <= 1'b0;
      term_q <= 16'hFFFF;
      lo_buf <= 8'hFF;
      cnt_q  <= 16'h0000;
      down_q <= 1'b0;
      ovf_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      down_q <= down_n;
      ovf_q  <= hit | (ovf_q & ~(wr_sts & ~reg_wdata[0]));
      pend_q <= (hit & mask_q) | (pend_q & ~(wr_sts & ~reg_wdata[1]));
      if (wr_ctl) begin
        mode_q <= reg_wdata[1:0];
        mask_q <= reg_wdata[2];
        ien_q  <= reg_wdata[3];
      end
      if (wr_tlo) lo_buf <= reg_wdata;
      if (wr_thi) term_q <= {reg_wdata, lo_buf};
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {4'b0, ien_q, mask_q, mode_q};
      3'd1:    reg_rdata = {6'b0, pend_q, ovf_q};
      3'd2:    reg_rdata = term_q[7:0];
      3'd3:    reg_rdata = term_q[15:8];
      3'd4:    reg_rdata = cnt_q[7:0];
      3'd5:    reg_rdata = cnt_q[15:8];
      default: reg_rdata = 8'h00;
    endcase
  end

  assign count      = cnt_q;
  assign count_down = down_q && (mode_q == M_UPDN);
  assign ovf_flag   = ovf_q;
  assign irq        = pend_q & mask_q & ien_q;
endmodule

// File: rtl/timer16_multimode_chk.sv
module timer16_multimode_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        reg_wr,
  input logic [2:0]  reg_addr,
  input logic [1:0]  mode_q,
  input logic [15:0] term_q,
  input logic [15:0] count,
  input logic        count_down,
  input logic        ovf_flag
);
  wire cw = reg_wr && (reg_addr == 3'd4 || reg_addr == 3'd5);

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cw) |=> $stable(count));

  assert_stop_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b00 && !cw) |=> $stable(count));

  assert_free_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cw && mode_q == 2'b01) |=> count == $past(count) + 16'd1);

  assert_mod_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cw && mode_q == 2'b10 && count <= term_q) |=> count <= $past(term_q));

  assert_down_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cw && count_down && count > 16'd1 && term_q != 16'h0000) |=> count == $past(count) - 16'd1);

  assert_flag_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(tick));

  assert_count_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cw |=> (count == 16'h0000 && !count_down));
endmodule

bind timer16_multimode timer16_multimode_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .mode_q(mode_q), .term_q(term_q), .count(count), .count_down(count_down),
  .ovf_flag(ovf_flag)
);

// File: tb/sim_timer16_multimode.sv
`timescale 1ns/1ps
module sim_timer16_multimode;
  logic clk = 0, rst_n = 0, tick = 0, reg_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic [15:0] count;
  logic count_down, ovf_flag, irq;
  int total = 0, bad = 0;

  logic [1:0] m_mode; logic m_mask, m_ien, m_dir, m_ovf, m_pend;
  logic [15:0] m_term, m_cnt; logic [7:0] m_lo;

  always #2.5 clk = ~clk;

  timer16_multimode u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .count(count),
    .count_down(count_down), .ovf_flag(ovf_flag), .irq(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_mode = 0; m_mask = 0; m_ien = 0; m_dir = 0; m_ovf = 0; m_pend = 0;
    m_term = 16'hFFFF; m_cnt = 0; m_lo = 8'hFF;
  endtask

  // next state of the reference, from the requirement text
  task automatic model_step(logic t, logic w, logic [2:0] a, logic [7:0] d);
    logic hit; logic [15:0] nc; logic nd;
    hit = 0; nc = m_cnt; nd = m_dir;
    if (t) begin
      if (m_mode == 2'b01) begin nc = m_cnt + 1; nd = 0; hit = (m_cnt == 16'hFFFF); end
      else if (m_mode == 2'b10) begin
        nd = 0;
        if (m_cnt >= m_term) begin nc = 0; hit = 1; end else nc = m_cnt + 1;
      end else if (m_mode == 2'b11) begin
        if (m_term == 0) begin nc = 0; nd = 0; hit = 1; end
        else if (!m_dir && m_cnt < m_term) nc = m_cnt + 1;
        else if (m_cnt <= 1) begin nc = 0; nd = 0; hit = 1; end
        else begin nc = m_cnt - 1; nd = 1; end
      end
    end
    if (w && (a == 4 || a == 5)) begin nc = 0; nd = 0; hit = 0; end
    m_ovf  = hit | (m_ovf & !(w && a == 1 && !d[0]));
    m_pend = (hit & m_mask) | (m_pend & !(w && a == 1 && !d[1]));
    if (w && a == 0) begin m_mode = d[1:0]; m_mask = d[2]; m_ien = d[3]; end
    if (w && a == 3) m_term = {d, m_lo};
    if (w && a == 2) m_lo = d;
    m_cnt = nc; m_dir = nd;
  endtask

  task automatic cyc(logic t, logic w = 0, logic [2:0] a = 0, logic [7:0] d = 0, bit cmp = 1);
    @(negedge clk);
    tick = t; reg_wr = w; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    model_step(t, w, a, d);
    #1;
    tick = 0; reg_wr = 0;
    if (cmp) begin
      chk("R1/R3/R4/R5/R6 count", count, m_cnt);
      chk("R5 count_down", count_down, m_dir && m_mode == 2'b11);
      chk("R8 ovf_flag", ovf_flag, m_ovf);
      chk("R10 irq", irq, m_pend & m_mask & m_ien);
    end
  endtask

  task automatic rd(string req, logic [2:0] a, logic [7:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  initial begin
    #1500000;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(posedge clk);
    rst_n = 1;
    #1;
    chk("R7 reset count", count, 16'h0000);
    chk("R8 reset flag", ovf_flag, 1'b0);
    rd("R7 reset term hi", 3, 8'hFF);
    rd("R12 unused addr", 6, 8'h00);
    rd("R2 reset ctrl", 0, 8'h00);

    // R2 stopped mode ignores ticks
    repeat (5) cyc(1);
    chk("R2 stopped hold", count, 16'h0000);

    // R7 buffered terminal: low only, then high
    cyc(0, 1, 2, 8'h05);
    rd("R7 low buffered, active unchanged", 2, 8'hFF);
    cyc(0, 1, 3, 8'h00);
    rd("R7 terminal low committed", 2, 8'h05);
    rd("R7 terminal high committed", 3, 8'h00);

    // R4 modulo with terminal 5, mask+enable
    cyc(0, 1, 0, 8'b1110);
    repeat (5) cyc(1);
    chk("R4 at terminal", count, 16'd5);
    cyc(1);
    chk("R4 reload", count, 16'd0);
    chk("R4 flag set", ovf_flag, 1'b1);
    chk("R10 irq raised", irq, 1'b1);
    rd("R9 pending read", 1, 8'h03);
    rd("R12 count low", 4, 8'h00);

    // R8 clear, then clear colliding with hardware set
    cyc(0, 1, 1, 8'h00);
    chk("R8 cleared", ovf_flag, 1'b0);
    cyc(0, 1, 1, 8'h03);
    chk("R8 write one no effect", ovf_flag, 1'b0);
    repeat (5) cyc(1);
    cyc(1, 1, 1, 8'h00);
    chk("R8 set wins over clear", ovf_flag, 1'b1);
    rd("R9 set wins over clear", 1, 8'h03);

    // R9 mask off: pending not set
    cyc(0, 1, 1, 8'h00);
    cyc(0, 1, 0, 8'b1010);
    repeat (6) cyc(1);
    chk("R9 mask off flag set", ovf_flag, 1'b1);
    rd("R9 mask off no pending", 1, 8'h01);
    chk("R10 no irq when masked", irq, 1'b0);

    // R5 up/down with terminal 3
    cyc(0, 1, 4, 8'h00);
    cyc(0, 1, 2, 8'h03); cyc(0, 1, 3, 8'h00);
    cyc(0, 1, 0, 8'b0111);
    repeat (3) cyc(1);
    chk("R5 top", count, 16'd3);
    cyc(1);
    chk("R5 falling", count_down, 1'b1);
    cyc(1); cyc(1);
    chk("R5 reach zero", count, 16'd0);
    chk("R5 rising again", count_down, 1'b0);

    // R11 count write wins over tick
    cyc(1); cyc(1);
    cyc(0, 1, 1, 8'h00);
    cyc(1, 1, 5, 8'hA5);
    chk("R11 count cleared", count, 16'd0);
    chk("R11 no flag", ovf_flag, 1'b0);

    // R6 terminal zero
    cyc(0, 1, 2, 8'h00); cyc(0, 1, 3, 8'h00);
    cyc(1); chk("R6 updn zero", count, 16'd0);
    cyc(0, 1, 1, 8'h00); cyc(1);
    chk("R6 flag each tick", ovf_flag, 1'b1);
    cyc(0, 1, 0, 8'b0110);
    cyc(0, 1, 1, 8'h00); cyc(1);
    chk("R6 modulo zero flag", ovf_flag, 1'b1);

    // random phase
    for (int i = 0; i < 20000; i++) begin
      int r = $urandom_range(0, 99);
      logic t = $urandom_range(0, 2) != 0;
      if (r < 2)      cyc(t, 1, 0, 8'($urandom_range(0, 15)));
      else if (r < 4) cyc(t, 1, 1, 8'($urandom_range(0, 3)));
      else if (r < 5) cyc(t, 1, 2, 8'($urandom_range(0, 40)));
      else if (r < 6) cyc(t, 1, 3, 8'($urandom_range(0, 1)));
      else if (r < 7) cyc(t, 1, 3'(4 + $urandom_range(0, 1)), 8'h00);
      else            cyc(t);
      if (i % 997 == 0) begin
        rd("R12 random count low", 4, m_cnt[7:0]);
        rd("R9 random status", 1, {6'b0, m_pend, m_ovf});
      end
    end

    // R3 full free-running wrap
    cyc(0, 1, 0, 8'b0101);
    cyc(0, 1, 4, 8'h00);
    cyc(0, 1, 1, 8'h00);
    for (int i = 0; i < 65535; i++) cyc(1, 0, 0, 0, 0);
    chk("R3 at top", count, 16'hFFFF);
    chk("R3 no flag before wrap", ovf_flag, 1'b0);
    rd("R12 count high", 5, 8'hFF);
    cyc(1);
    chk("R3 wrap to zero", count, 16'h0000);
    chk("R3 wrap flag", ovf_flag, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule